// File: doc/BRIEF.md
# Shared-Period Input Debounce Filter for an Eight-Pin Port

This block cleans up noisy input pins of one eight-pin port. Every raw pin first passes through a synchroniser. Each pin can then be filtered or passed straight through. A filtered pin changes its output only after its synchronised input has differed from the current output for a programmed number of millisecond ticks. The tick comes from a free-running prescaler that divides the core clock by a parameter.

All pins of the port share a single 8-bit period, counted in milliseconds, so the longest filter window is 255 ms. Each pin has its own enable bit. The enable bits are changed through a masked write, which lets software touch any subset of pins without a read-modify-write cycle.

Filtering can be left out at build time. In that case both configuration registers read as zero, writes to them have no effect, and every pin is passed through. Interrupt generation is not part of this block; a downstream block consumes the filtered outputs.

Top module: `dbnc_port_filter`

## Requirements
- R1: After reset the filtered outputs, the period register and the enable register are all zero.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata[7:0]` into the period register, and the value reads back on `cfg_period` on the next cycle. Bits 15:8 of such a write are ignored.
- R3: A write with `cfg_sel`=1 updates the enable register as a masked write.
  - Bits 15:8 of `cfg_wdata` select which pins change.
  - Bits 7:0 give the new values for the selected pins.
  - Pins whose select bit is 0 keep their old enable value.
- R4: A pin whose enable bit is 0 shows its raw input on `pin_filt` three clock edges after the input changes: two synchroniser stages plus the output register.
- R5: For a pin that is enabled with a nonzero period N, a change reaches `pin_filt` only after the input has held the new value across N millisecond ticks. The output therefore does not move within 2 ms of the change when N=3, and it has moved within about 3 ms plus the synchroniser delay.
- R6: A raw pulse on an enabled pin that is shorter than N-1 ticks never reaches `pin_filt`. When the input returns to the filtered value, the stability count restarts from zero.
- R7: A period of 0 turns filtering off for every pin, enabled or not, with the same latency as R4.
- R8: Clearing a pin's enable bit makes that pin's output take its synchronised input on the second clock edge after the write. Any pending filter count is discarded.
- R9: `ms_tick` is a one-cycle pulse that repeats every TICK_DIV clock cycles.
- R10: With DBNC_EN=0, `cfg_period` and `cfg_enable` always read 0, configuration writes have no effect, and all pins behave as in R4.
- R11: Pins are independent. In the same cycles, a bypassed pin follows its input while an enabled pin of the same port is still filtering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = period register, 1 = masked enable register |
| cfg_wdata | input | 16 | Write data: period in [7:0], or mask in [15:8] and values in [7:0] |
| pin_raw | input | 8 | Asynchronous raw pin levels |
| pin_filt | output | 8 | Filtered pin levels (registered) |
| cfg_period | output | 8 | Current shared period in milliseconds |
| cfg_enable | output | 8 | Current per-pin filter enables |
| ms_tick | output | 1 | Millisecond tick pulse |

## Verification
The hardest case is a filtered pin that must not change. To show that its output stays put, a pulse has to span some ticks but fewer than the period, and the check must fall at a point where the tick phase cannot matter. The bench works from the worst-case number of tick edges that a given window can contain. It places the "still old" checks where at most N-1 ticks can have passed and the "new value" checks where N ticks are certain. Clearing the enable bit while a count is pending is reached by starting a long-period filter and then issuing a masked clear part-way through the window.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Register select for the configuration write port
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_ENABLE = 1'b1
  } cfg_sel_e;

  // Mode a single pin is currently operating in
  typedef enum logic {
    MODE_PASS   = 1'b0,
    MODE_FILTER = 1'b1
  } pin_mode_e;

endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  generate
    if (TICK_DIV > 1) begin : g_tick_chk
      // R9: a tick never lasts more than one cycle
      a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d_async,
  output logic [PINS-1:0] d_sync
);
  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async[p]};
      end
      assign d_sync[p] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dbnc_cfg.sv
module dbnc_cfg
  import dbnc_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int CNT_W   = 8,
  parameter bit DBNC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [2*PINS-1:0] wdata,
  output logic [CNT_W-1:0]  period,
  output logic [PINS-1:0]   enable
);
  generate
    if (DBNC_EN) begin : g_regs
      logic [CNT_W-1:0] period_q;
      logic [PINS-1:0]  enable_q;
      logic [PINS-1:0]  sel_mask;
      logic [PINS-1:0]  new_vals;
      cfg_sel_e         sel_e;

      assign sel_e    = cfg_sel_e'(sel);
      assign sel_mask = wdata[2*PINS-1:PINS];
      assign new_vals = wdata[PINS-1:0];

      always_ff @(posedge clk) begin
        if (rst) begin
          period_q <= '0;
          enable_q <= '0;
        end else if (we) begin
          if (sel_e == SEL_PERIOD) period_q <= wdata[CNT_W-1:0];
          else enable_q <= (enable_q & ~sel_mask) | (new_vals & sel_mask);
        end
      end

      assign period = period_q;
      assign enable = enable_q;

      // R2: a period write lands on the next cycle
      a_r2_period_load: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 1'b0) |=> period_q == $past(wdata[CNT_W-1:0]));

      // R3: pins outside the write mask keep their enable
      a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 1'b1) |=>
          ((enable_q & ~$past(sel_mask)) == ($past(enable_q) & ~$past(sel_mask))));
    end else begin : g_absent
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, we, sel, wdata};
      assign period = '0;
      assign enable = '0;
    end
  endgenerate

endmodule

// File: rtl/dbnc_pin.sv
module dbnc_pin
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_sync,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic             tick,
  output logic             q
);
  pin_mode_e        mode;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;
  logic             reached;

  assign mode     = (en && period != '0) ? MODE_FILTER : MODE_PASS;
  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign reached  = cnt_next >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (mode == MODE_PASS) begin
      filt_q <= d_sync;
      cnt_q  <= '0;
    end else if (d_sync == filt_q) begin
      cnt_q  <= '0;
    end else if (tick) begin
      if (reached) begin
        filt_q <= d_sync;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_next[CNT_W-1:0];
      end
    end
  end

  assign q = filt_q;

  // R4: a bypassed pin copies its synchronised input
  a_r4_pass_follow: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PASS) |=> filt_q == $past(d_sync));

  // R5: a filtering pin moves only on a tick
  a_r5_tick_only: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FILTER && !tick) |=> $stable(filt_q));

  // R6: a filtering pin whose input matches its output stays put
  a_r6_match_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FILTER && d_sync == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/dbnc_port_filter.sv
module dbnc_port_filter #(
  parameter int PINS        = 8,
  parameter int CNT_W       = 8,
  parameter int TICK_DIV    = 200000,
  parameter int SYNC_STAGES = 2,
  parameter bit DBNC_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [2*PINS-1:0] cfg_wdata,
  input  logic [PINS-1:0]   pin_raw,
  output logic [PINS-1:0]   pin_filt,
  output logic [CNT_W-1:0]  cfg_period,
  output logic [PINS-1:0]   cfg_enable,
  output logic              ms_tick
);
  logic [PINS-1:0]  raw_sync;
  logic [CNT_W-1:0] period;
  logic [PINS-1:0]  enable;
  logic             tick;

  dbnc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dbnc_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pin_raw),
    .d_sync (raw_sync)
  );

  dbnc_cfg #(.PINS(PINS), .CNT_W(CNT_W), .DBNC_EN(DBNC_EN)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .period(period),
    .enable(enable)
  );

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      dbnc_pin #(.CNT_W(CNT_W)) u_pin (
        .clk   (clk),
        .rst   (rst),
        .d_sync(raw_sync[p]),
        .en    (enable[p]),
        .period(period),
        .tick  (tick),
        .q     (pin_filt[p])
      );
    end
  endgenerate

  assign cfg_period = period;
  assign cfg_enable = enable;
  assign ms_tick    = tick;

endmodule

// File: tb/dbnc_port_filter_bench.sv
module dbnc_port_filter_bench;
  localparam int DIV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  pin_raw = '0;
  logic [7:0]  filt_a, filt_b, per_a, per_b, en_a, en_b;
  logic        tick_a, tick_b;

  always #2.5 clk = ~clk;

  dbnc_port_filter #(.TICK_DIV(DIV), .DBNC_EN(1'b1)) u_dbnc_port_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pin_raw(pin_raw), .pin_filt(filt_a), .cfg_period(per_a), .cfg_enable(en_a),
    .ms_tick(tick_a));

  dbnc_port_filter #(.TICK_DIV(DIV), .DBNC_EN(1'b0)) u_dbnc_port_filter_nodbc (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pin_raw(pin_raw), .pin_filt(filt_b), .cfg_period(per_b), .cfg_enable(en_b),
    .ms_tick(tick_b));

  typedef struct {
    int         due;
    int         inst;   // 0 filtering build, 1 build without filter
    int         kind;   // 0 pin_filt, 1 cfg_period, 2 cfg_enable
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int delay, int inst, int kind, logic [7:0] exp,
                      logic [7:0] mask, string tag);
    exp_t e;
    e.due = cyc + delay; e.inst = inst; e.kind = kind;
    e.exp = exp; e.mask = mask; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Monitor: compare every expectation whose cycle has come
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [7:0] got;
        case (q[i].kind)
          0: got = (q[i].inst == 0) ? filt_a : filt_b;
          1: got = (q[i].inst == 0) ? per_a : per_b;
          default: got = (q[i].inst == 0) ? en_a : en_b;
        endcase
        check(q[i].tag, got & q[i].mask, q[i].exp & q[i].mask);
        q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(logic sel, logic [15:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    step(1);
    cfg_we = 1'b0;
  endtask

  // R9: tick spacing
  initial begin
    int last;
    @(negedge rst);
    @(posedge tick_a);
    last = cyc;
    for (int k = 0; k < 3; k++) begin
      @(posedge tick_a);
      check("R9 tick spacing", 8'(cyc - last), 8'(DIV));
      last = cyc;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    // R1 reset values
    push(1, 0, 0, 8'h00, 8'hFF, "R1 filt reset");
    push(1, 0, 1, 8'h00, 8'hFF, "R1 period reset");
    push(1, 0, 2, 8'h00, 8'hFF, "R1 enable reset");
    step(3);

    // R4 bypass latency
    pin_raw = 8'h5A;
    push(2, 0, 0, 8'h00, 8'hFF, "R4 not yet");
    push(3, 0, 0, 8'h5A, 8'hFF, "R4 follow");
    push(3, 1, 0, 8'h5A, 8'hFF, "R10 follow");
    step(6);

    // R2 period load, upper byte ignored
    push(1, 0, 1, 8'h03, 8'hFF, "R2 period");
    push(1, 1, 1, 8'h00, 8'hFF, "R10 period zero");
    cfg_write(1'b0, 16'hAB03);
    step(1);

    // R3 masked enable writes
    push(1, 0, 2, 8'hA5, 8'hFF, "R3 full write");
    cfg_write(1'b1, 16'hFFA5);
    push(1, 0, 2, 8'hA0, 8'hFF, "R3 low nibble clear");
    cfg_write(1'b1, 16'h0FF0);
    push(1, 0, 2, 8'hA3, 8'hFF, "R3 two bits set");
    push(1, 1, 2, 8'h00, 8'hFF, "R10 enable zero");
    cfg_write(1'b1, 16'h03FF);
    cfg_write(1'b1, 16'hFF01);   // only pin 0 filtered
    step(2);

    // R5 / R11: pin 0 filtered (period 3), pin 1 bypassed
    pin_raw = 8'h59;
    push(3,  0, 0, 8'h58, 8'hFF, "R11 bypass pin moves first");
    push(3,  1, 0, 8'h59, 8'hFF, "R10 no filtering");
    push(42, 0, 0, 8'h00, 8'h01, "R5 held before period");
    push(63, 0, 0, 8'h01, 8'h01, "R5 taken after period");
    step(70);

    // R6 short glitch on filtered pin
    pin_raw = 8'h58;
    push(25, 0, 0, 8'h01, 8'h01, "R6 glitch mid");
    step(30);
    pin_raw = 8'h59;
    push(50, 0, 0, 8'h01, 8'h01, "R6 glitch rejected");
    step(60);

    // R7 period zero bypasses an enabled pin
    cfg_write(1'b0, 16'h0000);
    pin_raw = 8'h58;
    push(3, 0, 0, 8'h00, 8'h01, "R7 zero period follow");
    step(6);

    // R8 clearing enable while a count is pending
    cfg_write(1'b0, 16'h000A);
    pin_raw = 8'h59;
    step(20);
    push(1, 0, 0, 8'h00, 8'h01, "R8 still filtering");
    push(2, 0, 0, 8'h01, 8'h01, "R8 follows after clear");
    cfg_write(1'b1, 16'h0100);
    step(8);

    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R1: %0d expectations never compared, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule